// File: doc/BRIEF.md
# Packed RGB888 to 16-bit Display Serializer

This block turns a frame buffer of packed 24-bit pixels into the stream of 16-bit words that a parallel 8080-style display bus carries. Frame memory arrives as 32-bit little-endian words. Each pixel takes three consecutive bytes, with blue at the lowest address, then green, then red. Pixels do not line up with word boundaries, so one pixel can be split across two input words. The block gathers the bytes in a small byte buffer and sends out two pixels as three half-words.

Two per-frame options adapt the byte order to the panel. The colour swap reverses the order of the three components inside each pixel to red, green, blue, and green stays in the middle. The lane swap exchanges the upper and lower bytes of every output half-word. A one-cycle frame-start pulse loads the pixel count and both options. The block then takes exactly as many input words as the frame needs and marks the final output half-word. A frame with an odd pixel count ends on a half-word whose unused byte is filled with zero. Both sides use valid/ready handshakes. Bus strobes and memory fetch are handled elsewhere.

Top module: `rgb_hw_serializer`

## Requirements
- R1: With both options off, byte k of the frame stream (byte 0 = in_data[7:0] of the first word) goes out in half-word k/2. An even k goes on out_data[7:0] and an odd k on out_data[15:8].
- R2: With the colour swap on, each pixel is emitted as red, green, blue (memory offsets +2, +1, +0) before the bytes are paired into half-words.
- R3: With the lane swap on, the earlier byte of each pair goes on out_data[15:8] and the later byte on out_data[7:0].
- R4: With both options on, pixels 0 and 1 give {R0,G0}, then {B0,R1}, then {G1,B1} as {out_data[15:8],out_data[7:0]}. The same pattern repeats for every later pair of pixels.
- R5: A frame of N pixels yields exactly ceil(3N/2) output half-words. out_last is high only on the final one, and out_valid stays low afterwards until the next frame start.
- R6: When N is odd, the byte position of the final half-word that holds no pixel data is zero.
- R7: in_ready goes high for exactly ceil(3N/4) accepted words per frame, and never while the byte buffer has fewer than 4 free byte slots.
- R8: While out_valid is high and out_ready is low, out_valid and out_data hold their values until the transfer completes, unless a frame start intervenes.
- R9: rb_swap and byte_swap are sampled only in the frame-start cycle. Changing them during a frame does not alter that frame's output.
- R10: After reset, out_valid and in_ready are low.
- R11: A frame start discards any bytes left in the buffer from an unfinished frame. The first output of the new frame comes only from the new frame's words.
- R12: A frame start with a pixel count of zero leaves in_ready and out_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that begins a frame |
| pix_count | input | PIX_W | Pixels in the frame, sampled at frame_start |
| rb_swap | input | 1 | Colour order swap, sampled at frame_start |
| byte_swap | input | 1 | Half-word lane swap, sampled at frame_start |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 32 | Little-endian frame memory word |
| out_valid | output | 1 | Output half-word valid |
| out_ready | input | 1 | Display side accepts the half-word |
| out_data | output | 16 | Display bus data word |
| out_last | output | 1 | Marks the final half-word of the frame |

## Verification
If the pair phase or the buffer read offset is wrong, the affected half-word shows it: its bytes come from the wrong pixel position, or a component shows up twice. This is caught on the first mismatched output of the frame, compared against a stream built from the requirements. A wrong pixel or word counter shows at the end of the frame. out_last then lands on the wrong half-word, or in_ready stays high past the word budget, or the output stalls for good, which the watchdog catches. A wrong sampled option corrupts every half-word of the frame from its first transfer.

// File: rtl/rgbser_pkg.sv
package rgbser_pkg;

    typedef logic [7:0] byte_t;

    typedef struct packed {
        logic rb_swap;
        logic byte_swap;
    } swap_cfg_t;

    // position of the current half-word inside a pair of pixels
    typedef enum logic [1:0] {
        PH0 = 2'd0,
        PH1 = 2'd1,
        PH2 = 2'd2
    } hw_phase_t;

    localparam int IN_BYTES  = 4;
    localparam int WIN_BYTES = 6;

    // bytes that must be buffered (from the pair base) before a phase can go out
    function automatic logic [2:0] need_bytes(hw_phase_t ph, logic rb, logic single);
        case (ph)
            PH0:     return rb ? 3'd3 : 3'd2;
            PH1:     return single ? 3'd3 : (rb ? 3'd6 : 3'd4);
            default: return 3'd6;
        endcase
    endfunction

    // first = earlier byte of the pair after colour reordering
    function automatic logic [15:0] place(byte_t first, byte_t second, logic bs);
        return bs ? {first, second} : {second, first};
    endfunction

endpackage

// File: rtl/rgbser_accum.sv
module rgbser_accum
    import rgbser_pkg::*;
#(
    parameter int BUF_BYTES = 10,
    parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clear_i,
    input  logic                        push_i,
    input  logic [IN_BYTES*8-1:0]       push_word_i,
    input  logic [CNT_W-1:0]            pop_i,
    output logic [CNT_W-1:0]            cnt_o,
    output byte_t [WIN_BYTES-1:0]       win_o
);

    byte_t [BUF_BYTES-1:0] buf_q, buf_d;
    logic  [CNT_W-1:0]     cnt_q, cnt_d;
    int                    base_i;

    always_comb begin
        base_i = int'(cnt_q) - int'(pop_i);
        for (int i = 0; i < BUF_BYTES; i++) begin
            buf_d[i] = '0;
            if ((i + int'(pop_i) < int'(cnt_q)) && (i + int'(pop_i) < BUF_BYTES))
                buf_d[i] = buf_q[i + int'(pop_i)];
            if (push_i) begin
                for (int k = 0; k < IN_BYTES; k++) begin
                    if (i == base_i + k)
                        buf_d[i] = push_word_i[k*8 +: 8];
                end
            end
        end
        cnt_d = CNT_W'(base_i + (push_i ? IN_BYTES : 0));
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            buf_q <= '0;
            cnt_q <= '0;
        end else begin
            buf_q <= buf_d;
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    generate
        for (genvar w = 0; w < WIN_BYTES; w++) begin : g_win
            assign win_o[w] = buf_q[w];
        end
    endgenerate

    // R7
    push_room_chk: assert property (@(posedge clk) disable iff (rst)
        push_i |-> (int'(cnt_q) - int'(pop_i) + IN_BYTES <= BUF_BYTES));

    // R5
    pop_le_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        pop_i <= cnt_q);

endmodule

// File: rtl/rgbser_seq.sv
module rgbser_seq
    import rgbser_pkg::*;
#(
    parameter int PIX_W     = 16,
    parameter int BUF_BYTES = 10,
    parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start_i,
    input  logic [PIX_W-1:0] pix_count_i,
    input  swap_cfg_t        cfg_i,
    input  logic             in_valid_i,
    input  logic             out_ready_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             in_ready_o,
    output logic             push_o,
    output logic             out_valid_o,
    output logic             out_last_o,
    output logic [CNT_W-1:0] pop_o,
    output hw_phase_t        phase_o,
    output logic             single_o,
    output swap_cfg_t        cfg_o
);

    localparam int TOT_W = PIX_W + 2;

    logic             active_q;
    swap_cfg_t        cfg_q;
    hw_phase_t        phase_q;
    logic [PIX_W-1:0] pix_left_q;
    logic [PIX_W-1:0] words_left_q;
    logic [TOT_W-1:0] words_tot;
    logic             single, pair_end, hw_fire;

    assign words_tot   = (TOT_W'(pix_count_i) * TOT_W'(3) + TOT_W'(3)) >> 2;
    assign single      = (pix_left_q == PIX_W'(1));
    assign in_ready_o  = active_q && !frame_start_i && (words_left_q != '0)
                         && (int'(cnt_i) <= BUF_BYTES - IN_BYTES);
    assign push_o      = in_ready_o && in_valid_i;
    assign out_valid_o = active_q && !frame_start_i
                         && (cnt_i >= CNT_W'(need_bytes(phase_q, cfg_q.rb_swap, single)));
    assign hw_fire     = out_valid_o && out_ready_i;
    assign pair_end    = single ? (phase_q == PH1) : (phase_q == PH2);
    assign out_last_o  = pair_end && (pix_left_q <= PIX_W'(2));
    assign pop_o       = (hw_fire && pair_end) ? CNT_W'(single ? 3 : 6) : '0;
    assign phase_o     = phase_q;
    assign single_o    = single;
    assign cfg_o       = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q     <= 1'b0;
            cfg_q        <= '0;
            phase_q      <= PH0;
            pix_left_q   <= '0;
            words_left_q <= '0;
        end else if (frame_start_i) begin
            active_q     <= (pix_count_i != '0);
            cfg_q        <= cfg_i;
            phase_q      <= PH0;
            pix_left_q   <= pix_count_i;
            words_left_q <= PIX_W'(words_tot);
        end else begin
            if (push_o)
                words_left_q <= words_left_q - PIX_W'(1);
            if (hw_fire) begin
                if (pair_end) begin
                    phase_q    <= PH0;
                    pix_left_q <= single ? '0 : pix_left_q - PIX_W'(2);
                    if (out_last_o)
                        active_q <= 1'b0;
                end else begin
                    phase_q <= hw_phase_t'(phase_q + 2'd1);
                end
            end
        end
    end

    // R5
    frame_end_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_fire && out_last_o) |=> !out_valid_o);

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_start_i |=> $stable(cfg_q));

    // R8
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i) |=> (out_valid_o || frame_start_i));

endmodule

// File: rtl/rgbser_pack.sv
module rgbser_pack
    import rgbser_pkg::*;
(
    input  byte_t [WIN_BYTES-1:0] win_i,
    input  hw_phase_t             phase_i,
    input  logic                  single_i,
    input  swap_cfg_t             cfg_i,
    output logic [15:0]           data_o
);

    byte_t first, second;

    always_comb begin
        case (phase_i)
            PH0: begin
                first  = cfg_i.rb_swap ? win_i[2] : win_i[0];
                second = win_i[1];
            end
            PH1: begin
                first  = cfg_i.rb_swap ? win_i[0] : win_i[2];
                second = single_i ? 8'h00 : (cfg_i.rb_swap ? win_i[5] : win_i[3]);
            end
            default: begin
                first  = win_i[4];
                second = cfg_i.rb_swap ? win_i[3] : win_i[5];
            end
        endcase
        data_o = place(first, second, cfg_i.byte_swap);
    end

endmodule

// File: rtl/rgb_hw_serializer.sv
module rgb_hw_serializer
    import rgbser_pkg::*;
#(
    parameter int PIX_W     = 16,
    parameter int BUF_BYTES = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic [PIX_W-1:0] pix_count,
    input  logic             rb_swap,
    input  logic             byte_swap,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [15:0]      out_data,
    output logic             out_last
);

    localparam int CNT_W = $clog2(BUF_BYTES + 1);

    logic                   push;
    logic [CNT_W-1:0]       pop, cnt;
    byte_t [WIN_BYTES-1:0]  win;
    hw_phase_t              phase;
    logic                   single;
    swap_cfg_t              cfg_in, cfg_cur;

    assign cfg_in = '{rb_swap: rb_swap, byte_swap: byte_swap};

    rgbser_seq #(.PIX_W(PIX_W), .BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .frame_start_i (frame_start),
        .pix_count_i   (pix_count),
        .cfg_i         (cfg_in),
        .in_valid_i    (in_valid),
        .out_ready_i   (out_ready),
        .cnt_i         (cnt),
        .in_ready_o    (in_ready),
        .push_o        (push),
        .out_valid_o   (out_valid),
        .out_last_o    (out_last),
        .pop_o         (pop),
        .phase_o       (phase),
        .single_o      (single),
        .cfg_o         (cfg_cur)
    );

    rgbser_accum #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_accum (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (frame_start),
        .push_i      (push),
        .push_word_i (in_data),
        .pop_i       (pop),
        .cnt_o       (cnt),
        .win_o       (win)
    );

    rgbser_pack u_pack (
        .win_i    (win),
        .phase_i  (phase),
        .single_i (single),
        .cfg_i    (cfg_cur),
        .data_o   (out_data)
    );

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (frame_start || $stable(out_data)));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !in_ready));

endmodule

// File: tb/sim_rgb_hw_serializer.sv
module sim_rgb_hw_serializer;

    localparam int PIX_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             frame_start = 1'b0;
    logic [PIX_W-1:0] pix_count = '0;
    logic             rb_swap = 1'b0;
    logic             byte_swap = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [31:0]      in_data = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [15:0]      out_data;
    logic             out_last;

    int total = 0;
    int bad   = 0;

    logic [7:0]  mem   [0:255];
    logic [7:0]  strm  [0:255];
    logic [15:0] exp_q [0:127];

    always #2.5 clk = ~clk;

    rgb_hw_serializer #(.PIX_W(PIX_W), .BUF_BYTES(10)) u0 (
        .clk(clk), .rst(rst), .frame_start(frame_start), .pix_count(pix_count),
        .rb_swap(rb_swap), .byte_swap(byte_swap), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected half-words built from the requirements
    function automatic int build_exp(int n, bit rb, bit bs);
        int sl = 0;
        for (int p = 0; p < n; p++) begin
            if (rb) begin
                strm[sl] = mem[3*p+2]; strm[sl+1] = mem[3*p+1]; strm[sl+2] = mem[3*p];
            end else begin
                strm[sl] = mem[3*p]; strm[sl+1] = mem[3*p+1]; strm[sl+2] = mem[3*p+2];
            end
            sl += 3;
        end
        if (n % 2 == 1) begin
            strm[sl] = 8'h00;
            sl++;
        end
        for (int j = 0; j < sl / 2; j++)
            exp_q[j] = bs ? {strm[2*j], strm[2*j+1]} : {strm[2*j+1], strm[2*j]};
        return sl / 2;
    endfunction

    task automatic start_frame(int n, bit rb, bit bs);
        frame_start = 1'b1;
        pix_count   = PIX_W'(n);
        rb_swap     = rb;
        byte_swap   = bs;
        in_valid    = 1'b0;
        out_ready   = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic run_frame(int n, bit rb, bit bs, bit toggle, string tag);
        int nhw, nwords, wi, oi, guard;
        bit over_budget, hold_pend;
        logic [15:0] hold_val;
        for (int i = 0; i < 3*n + 8; i++) mem[i] = 8'($urandom);
        nhw    = build_exp(n, rb, bs);
        nwords = (3*n + 3) / 4;
        start_frame(n, rb, bs);
        wi = 0; oi = 0; guard = 0; over_budget = 0; hold_pend = 0; hold_val = '0;
        while (oi < nhw && guard < 5000) begin
            in_valid  = (wi < nwords) && ($urandom % 4 != 0);
            in_data   = {mem[4*wi+3], mem[4*wi+2], mem[4*wi+1], mem[4*wi]};
            out_ready = ($urandom % 4 != 0);
            if (toggle) begin
                rb_swap   = 1'($urandom);
                byte_swap = 1'($urandom);
            end
            #1;
            if (hold_pend)
                chk(out_valid && out_data == hold_val, "R8 held data",
                    {15'd0, out_valid, out_data}, {16'd1, hold_val});
            hold_pend = out_valid && !out_ready;
            hold_val  = out_data;
            if (in_ready && wi >= nwords) over_budget = 1;
            if (in_valid && in_ready) wi++;
            if (out_valid && out_ready) begin
                chk(out_data == exp_q[oi], tag, 32'(out_data), 32'(exp_q[oi]));
                chk(out_last == (oi == nhw - 1), "R5 last flag",
                    32'(out_last), 32'(oi == nhw - 1));
                oi++;
            end
            guard++;
            @(negedge clk);
        end
        in_valid  = 1'b1;
        out_ready = 1'b1;
        chk(oi == nhw, "R5 count", 32'(oi), 32'(nhw));
        chk(wi == nwords, "R7 words taken", 32'(wi), 32'(nwords));
        for (int c = 0; c < 4; c++) begin
            #1;
            if (in_ready) over_budget = 1;
            chk(!out_valid, "R5 quiet after last", 32'(out_valid), 32'd0);
            @(negedge clk);
        end
        chk(!over_budget, "R7 ready beyond budget", 32'(over_budget), 32'd0);
        in_valid  = 1'b0;
        out_ready = 1'b0;
        rb_swap   = 1'b0;
        byte_swap = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R5 watchdog expired", 32'd0, 32'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid && !in_ready, "R10 reset state",
            {30'd0, out_valid, in_ready}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        run_frame(4, 0, 0, 0, "R1 plain order");
        run_frame(5, 1, 0, 0, "R2 colour swap");
        run_frame(4, 0, 1, 0, "R3 lane swap");
        run_frame(2, 1, 1, 0, "R4 both swaps");
        run_frame(1, 0, 0, 0, "R6 single pixel pad");
        run_frame(3, 1, 1, 0, "R6 odd pad both swaps");
        run_frame(7, 0, 1, 0, "R6 odd pad lane swap");
        run_frame(9, 1, 0, 1, "R9 options toggled mid-frame");

        // R12: zero pixels
        start_frame(0, 1, 1);
        in_valid = 1'b1;
        out_ready = 1'b1;
        for (int c = 0; c < 6; c++) begin
            #1;
            chk(!in_ready && !out_valid, "R12 zero count idle",
                {30'd0, in_ready, out_valid}, 32'd0);
            @(negedge clk);
        end
        in_valid = 1'b0;

        // R11: abandon a frame with bytes buffered, then start a new one
        start_frame(10, 0, 0);
        n0 = 0;
        in_data = 32'hA5A5_A5A5;
        while (n0 < 2) begin
            in_valid = 1'b1;
            #1;
            if (in_ready) n0++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        run_frame(4, 1, 0, 0, "R11 after discard");

        for (int f = 0; f < 30; f++)
            run_frame(1 + int'($urandom % 60), 1'($urandom), 1'($urandom), 0,
                      "R1 random frame");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule